// File: doc/BRIEF.md
# SD Host Line-State Tracker

This block holds the live state of an SD/MMC host's command and data lines. Strobes from the command engine and the data engine drive it. It keeps three flags: the command line is inhibited, the data line is inhibited, and a data transfer is active. From these flags it derives two qualifiers that tell the issuing logic whether a command may start. One qualifier covers commands that use only the command line. The other covers commands that also need the data lines. The same flags produce three one-clock interrupt pulses: command complete, transfer complete and block-gap event.

The issuing logic raises `cmd_wr_i` when it writes a command. In the same cycle it says whether the command moves data, in which direction, and whether the response carries a busy phase. The tracker latches the direction. That direction then picks which rules apply to the data-active flag, read or write. A read that stops at a block gap keeps the data line inhibited, because read wait is held until a continue request arrives. A write that stops at a gap releases the data line once the card drops busy.

Top module: `sd_line_tracker`

## Requirements
- R1: After synchronous reset, all three flags and all three interrupt outputs are 0, and both issue qualifiers are 1.
- R2: The command-line inhibit flag is 1 in the cycle after `cmd_wr_i`. It returns to 0 in the cycle after `rsp_done_i`. `cc_irq_o` is 1 for exactly the first cycle in which the flag is 0 again.
- R3: When `rsp_done_i` arrives together with `cmd_conflict_i`, the command-line inhibit flag stays 1 and `cc_irq_o` is not raised.
- R4: `may_cmd_o` is 1 whenever command-line inhibit is 0, whatever the state of data-line inhibit. `may_dat_o` is 1 only when both inhibit flags are 0.
- R5: Data-line inhibit is 1 from the cycle after a command write with `cmd_uses_dat_i` set, until that transfer ends. It is also 1 in any cycle in which `rdwait_i` is high. Its fall from 1 to 0 raises `tc_irq_o` for one cycle.
- R6: A command written with `cmd_busy_i` holds data-line inhibit at 1 until `busy_rel_i` or `no_busy_i` arrives.
- R7: With the read direction latched, data-active becomes 1 in the cycle after `end_bit_i` of the read command, or after `cont_req_i`.
- R8: With the read direction latched, `last_blk_i` or `gap_stop_i` clears data-active, and the fall raises `bge_irq_o` for one cycle. After `gap_stop_i`, read wait keeps data-line inhibit at 1 with no transfer-complete pulse, until `cont_req_i` sets data-active again.
- R9: With the write direction latched, data-active is set after `end_bit_i` or `cont_req_i`. It is cleared by `busy_rel_i`, `no_busy_i` or `gap_stop_i`. Its fall raises `tc_irq_o` and never `bge_irq_o`.
- R10: Each interrupt output is high for a single cycle per falling edge of its flag.
- R11: `end_bit_i` with no data transfer open leaves data-active at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_i | input | 1 | Command register written (strobe) |
| cmd_uses_dat_i | input | 1 | Written command moves data |
| cmd_is_read_i | input | 1 | Data direction of written command, 1 = read |
| cmd_busy_i | input | 1 | Written command has a busy-type response |
| rsp_done_i | input | 1 | Command response received (strobe) |
| cmd_conflict_i | input | 1 | Command not issued: conflict or auto-stop error |
| end_bit_i | input | 1 | End bit of the command sent (strobe) |
| last_blk_i | input | 1 | End bit of last read block received (strobe) |
| busy_rel_i | input | 1 | Card released busy after last block (strobe) |
| no_busy_i | input | 1 | No busy driven after CRC status (strobe) |
| gap_stop_i | input | 1 | Transfer halted at block gap (strobe) |
| cont_req_i | input | 1 | Continue request (strobe) |
| rdwait_i | input | 1 | Read wait driven because the buffer is full (level) |
| cmd_inh_o | output | 1 | Command-line inhibit flag |
| dat_inh_o | output | 1 | Data-line inhibit flag |
| dat_act_o | output | 1 | Data transfer active flag |
| may_cmd_o | output | 1 | A command-line-only command may be issued |
| may_dat_o | output | 1 | A command using the data lines may be issued |
| cc_irq_o | output | 1 | Command-complete pulse |
| tc_irq_o | output | 1 | Transfer-complete pulse |
| bge_irq_o | output | 1 | Block-gap-event pulse |

## Verification
A wrong latched direction shows up in the first cycle after data-active falls. The pulse appears on the block-gap output instead of the transfer-complete output, or the other way round. A flag stuck at 1 holds the matching issue qualifier at 0, and that is visible one cycle after the strobe that should have cleared it. A lost pulse or a doubled pulse is seen in the cycle right after the flag falls. Every vector step compares all eight outputs one clock after its strobe. Read wait is also checked within the same cycle it drops.

// File: rtl/sdlt_pkg.sv
package sdlt_pkg;

    typedef enum logic [1:0] {
        XDIR_NONE  = 2'd0,
        XDIR_READ  = 2'd1,
        XDIR_WRITE = 2'd2
    } xfer_dir_e;

    typedef struct packed {
        logic wr;
        logic uses_dat;
        logic is_read;
        logic busy_type;
    } cmd_req_t;

    typedef struct packed {
        logic end_bit;
        logic last_blk;
        logic busy_rel;
        logic no_busy;
        logic gap_stop;
        logic cont_req;
    } dat_evt_t;

    localparam int FLAG_CMD_INH = 0;
    localparam int FLAG_DAT_INH = 1;
    localparam int FLAG_DAT_ACT = 2;
    localparam int NUM_FLAGS    = 3;

    function automatic xfer_dir_e pick_dir(input logic is_read);
        return is_read ? XDIR_READ : XDIR_WRITE;
    endfunction

endpackage

// File: rtl/sdlt_cmd_track.sv
module sdlt_cmd_track
    import sdlt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmd_req_t cmd,
    input  logic     rsp_done,
    input  logic     conflict,
    output logic     cmd_inh
);
    logic inh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inh_q <= 1'b0;
        end else if (cmd.wr) begin
            inh_q <= 1'b1;
        end else if (rsp_done && !conflict) begin
            inh_q <= 1'b0;
        end
    end

    assign cmd_inh = inh_q;
endmodule

// File: rtl/sdlt_dat_track.sv
module sdlt_dat_track
    import sdlt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmd_req_t  cmd,
    input  dat_evt_t  evt,
    input  logic      rdwait,
    output logic      dat_inh,
    output logic      dat_act,
    output xfer_dir_e dir
);
    xfer_dir_e dir_q, dir_n;
    logic open_q, open_n;
    logic rw_q, rw_n;
    logic busy_q, busy_n;
    logic act_q, act_n;
    logic is_rd, is_wr;

    assign is_rd = (dir_q == XDIR_READ);
    assign is_wr = (dir_q == XDIR_WRITE);

    always_comb begin
        dir_n  = dir_q;
        open_n = open_q;
        rw_n   = rw_q;
        busy_n = busy_q;
        act_n  = act_q;

        if (evt.busy_rel || evt.no_busy) busy_n = 1'b0;

        if (is_rd) begin
            if (evt.last_blk) begin
                act_n  = 1'b0;
                open_n = 1'b0;
                rw_n   = 1'b0;
            end
            if (evt.gap_stop) begin
                act_n = 1'b0;
                rw_n  = 1'b1;
            end
            if (evt.cont_req) begin
                act_n = 1'b1;
                rw_n  = 1'b0;
            end
            if (evt.end_bit && open_q) act_n = 1'b1;
        end

        if (is_wr) begin
            if (evt.busy_rel || evt.no_busy || evt.gap_stop) begin
                act_n  = 1'b0;
                open_n = 1'b0;
            end
            if (evt.cont_req) act_n = 1'b1;
            if (evt.end_bit && open_q) act_n = 1'b1;
        end

        if (cmd.wr && cmd.busy_type) busy_n = 1'b1;
        if (cmd.wr && cmd.uses_dat) begin
            dir_n  = pick_dir(cmd.is_read);
            open_n = 1'b1;
            act_n  = 1'b0;
            rw_n   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= XDIR_NONE;
            open_q <= 1'b0;
            rw_q   <= 1'b0;
            busy_q <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            dir_q  <= dir_n;
            open_q <= open_n;
            rw_q   <= rw_n;
            busy_q <= busy_n;
            act_q  <= act_n;
        end
    end

    assign dat_inh = act_q | open_q | rw_q | busy_q | rdwait;
    assign dat_act = act_q;
    assign dir     = dir_q;
endmodule

// File: rtl/sdlt_fall_det.sv
module sdlt_fall_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[i];
        end
        assign fall[i] = prev_q & ~lvl[i];
    end
endmodule

// File: rtl/sd_line_tracker.sv
module sd_line_tracker
    import sdlt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr_i,
    input  logic cmd_uses_dat_i,
    input  logic cmd_is_read_i,
    input  logic cmd_busy_i,
    input  logic rsp_done_i,
    input  logic cmd_conflict_i,
    input  logic end_bit_i,
    input  logic last_blk_i,
    input  logic busy_rel_i,
    input  logic no_busy_i,
    input  logic gap_stop_i,
    input  logic cont_req_i,
    input  logic rdwait_i,
    output logic cmd_inh_o,
    output logic dat_inh_o,
    output logic dat_act_o,
    output logic may_cmd_o,
    output logic may_dat_o,
    output logic cc_irq_o,
    output logic tc_irq_o,
    output logic bge_irq_o
);
    cmd_req_t              cmd;
    dat_evt_t              evt;
    xfer_dir_e             dir;
    logic                  cmd_inh, dat_inh, dat_act;
    logic [NUM_FLAGS-1:0]  flags, falls;

    assign cmd = '{wr: cmd_wr_i, uses_dat: cmd_uses_dat_i,
                   is_read: cmd_is_read_i, busy_type: cmd_busy_i};
    assign evt = '{end_bit: end_bit_i, last_blk: last_blk_i,
                   busy_rel: busy_rel_i, no_busy: no_busy_i,
                   gap_stop: gap_stop_i, cont_req: cont_req_i};

    sdlt_cmd_track u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .rsp_done (rsp_done_i),
        .conflict (cmd_conflict_i),
        .cmd_inh  (cmd_inh)
    );

    sdlt_dat_track u_dat (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .evt     (evt),
        .rdwait  (rdwait_i),
        .dat_inh (dat_inh),
        .dat_act (dat_act),
        .dir     (dir)
    );

    always_comb begin
        flags               = '0;
        flags[FLAG_CMD_INH] = cmd_inh;
        flags[FLAG_DAT_INH] = dat_inh;
        flags[FLAG_DAT_ACT] = dat_act;
    end

    sdlt_fall_det #(.W(NUM_FLAGS)) u_fall (
        .clk  (clk),
        .rst  (rst),
        .lvl  (flags),
        .fall (falls)
    );

    assign cmd_inh_o = cmd_inh;
    assign dat_inh_o = dat_inh;
    assign dat_act_o = dat_act;
    assign may_cmd_o = ~cmd_inh;
    assign may_dat_o = ~cmd_inh & ~dat_inh;
    assign cc_irq_o  = falls[FLAG_CMD_INH];
    assign tc_irq_o  = falls[FLAG_DAT_INH] |
                       (falls[FLAG_DAT_ACT] & (dir == XDIR_WRITE));
    assign bge_irq_o = falls[FLAG_DAT_ACT] & (dir == XDIR_READ);
endmodule

// File: rtl/sd_line_tracker_chk.sv
module sd_line_tracker_chk (
    input logic clk,
    input logic rst,
    input logic cmd_wr_i,
    input logic rsp_done_i,
    input logic cmd_conflict_i,
    input logic rdwait_i,
    input logic cmd_inh_o,
    input logic dat_inh_o,
    input logic dat_act_o,
    input logic may_cmd_o,
    input logic may_dat_o,
    input logic cc_irq_o,
    input logic tc_irq_o,
    input logic bge_irq_o
);
    p_cmd_set_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_wr_i |=> cmd_inh_o);

    p_cc_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_inh_o) |-> cc_irq_o);

    p_conflict_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_inh_o && rsp_done_i && cmd_conflict_i && !cmd_wr_i) |=> (cmd_inh_o && !cc_irq_o));

    p_qual_order_r4: assert property (@(posedge clk) disable iff (rst)
        may_dat_o |-> (may_cmd_o && !dat_inh_o));

    p_rdwait_inh_r5: assert property (@(posedge clk) disable iff (rst)
        rdwait_i |-> dat_inh_o);

    p_bge_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        bge_irq_o |-> (!dat_act_o && $past(dat_act_o)));

    p_tc_single_r10: assert property (@(posedge clk) disable iff (rst)
        tc_irq_o |=> !tc_irq_o);

    p_cc_single_r10: assert property (@(posedge clk) disable iff (rst)
        cc_irq_o |=> !cc_irq_o);
endmodule

bind sd_line_tracker sd_line_tracker_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_wr_i       (cmd_wr_i),
    .rsp_done_i     (rsp_done_i),
    .cmd_conflict_i (cmd_conflict_i),
    .rdwait_i       (rdwait_i),
    .cmd_inh_o      (cmd_inh_o),
    .dat_inh_o      (dat_inh_o),
    .dat_act_o      (dat_act_o),
    .may_cmd_o      (may_cmd_o),
    .may_dat_o      (may_dat_o),
    .cc_irq_o       (cc_irq_o),
    .tc_irq_o       (tc_irq_o),
    .bge_irq_o      (bge_irq_o)
);

// File: tb/sd_line_tracker_tb_top.sv
module sd_line_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;
    localparam int WATCHDOG_CYC = 5000;

    // stimulus bits [18:6]: wr uses rd busy rsp cfl end last brel nob gap cont rdw
    // expected bits [5:0]: cmd_inh dat_inh dat_act cc tc bge
    localparam logic [18:0] VEC [NVEC] = '{
        {13'b1110000000000, 6'b110000},
        {13'b0000100000000, 6'b010100},
        {13'b0000001000000, 6'b011000},
        {13'b0000000000100, 6'b010001},
        {13'b0000000000000, 6'b010000},
        {13'b0000000000010, 6'b011000},
        {13'b0000000100000, 6'b000011},
        {13'b0000000000000, 6'b000000},
        {13'b1100000000000, 6'b110000},
        {13'b0000100000000, 6'b010100},
        {13'b0000001000000, 6'b011000},
        {13'b0000000010000, 6'b000010},
        {13'b1001000000000, 6'b110000},
        {13'b0000110000000, 6'b110000},
        {13'b0000100000000, 6'b010100},
        {13'b0000000001000, 6'b000010},
        {13'b0000001000000, 6'b000000},
        {13'b1100000000000, 6'b110000},
        {13'b0000100000000, 6'b010100},
        {13'b0000001000000, 6'b011000},
        {13'b0000000000100, 6'b000010},
        {13'b0000000000010, 6'b011000},
        {13'b0000000001000, 6'b000010},
        {13'b0000000000001, 6'b010000},
        {13'b0000000000001, 6'b010000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [12:0] stim = '0;
    logic cmd_inh_o, dat_inh_o, dat_act_o, may_cmd_o, may_dat_o;
    logic cc_irq_o, tc_irq_o, bge_irq_o;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_line_tracker dut_i (
        .clk            (clk),
        .rst            (rst),
        .cmd_wr_i       (stim[12]),
        .cmd_uses_dat_i (stim[11]),
        .cmd_is_read_i  (stim[10]),
        .cmd_busy_i     (stim[9]),
        .rsp_done_i     (stim[8]),
        .cmd_conflict_i (stim[7]),
        .end_bit_i      (stim[6]),
        .last_blk_i     (stim[5]),
        .busy_rel_i     (stim[4]),
        .no_busy_i      (stim[3]),
        .gap_stop_i     (stim[2]),
        .cont_req_i     (stim[1]),
        .rdwait_i       (stim[0]),
        .cmd_inh_o      (cmd_inh_o),
        .dat_inh_o      (dat_inh_o),
        .dat_act_o      (dat_act_o),
        .may_cmd_o      (may_cmd_o),
        .may_dat_o      (may_dat_o),
        .cc_irq_o       (cc_irq_o),
        .tc_irq_o       (tc_irq_o),
        .bge_irq_o      (bge_irq_o)
    );

    function automatic string tag_of(input int idx);
        case (idx)
            0, 8, 17, 23, 24: return "R5";
            1, 14, 18:        return "R2";
            2:                return "R7";
            3, 4, 5:          return "R8";
            6, 7:             return "R10";
            9:                return "R4";
            10, 11, 19, 20, 21, 22: return "R9";
            12, 15:           return "R6";
            13:               return "R3";
            default:          return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [5:0] e);
        check(req, "cmd_inh", cmd_inh_o, e[5]);
        check(req, "dat_inh", dat_inh_o, e[4]);
        check(req, "dat_act", dat_act_o, e[3]);
        check(req, "cc_irq",  cc_irq_o,  e[2]);
        check(req, "tc_irq",  tc_irq_o,  e[1]);
        check(req, "bge_irq", bge_irq_o, e[0]);
        check(req, "may_cmd", may_cmd_o, !e[5]);
        check(req, "may_dat", may_dat_o, !e[5] && !e[4]);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_all("R1", 6'b000000);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            stim = VEC[i][18:6];
            @(posedge clk);
            #1;
            check_all(tag_of(i), VEC[i][5:0]);
        end

        // R5/R10: read wait drop clears inhibit in the same cycle, pulse lasts one cycle
        @(negedge clk);
        stim = '0;
        #1;
        check("R5", "dat_inh after rdwait drop", dat_inh_o, 1'b0);
        check("R5", "tc_irq after rdwait drop", tc_irq_o, 1'b1);
        @(posedge clk);
        #1;
        check("R10", "tc_irq next cycle", tc_irq_o, 1'b0);

        // R1: reset in the middle of an active read
        @(negedge clk);
        stim = 13'b1110000000000;
        @(negedge clk);
        stim = 13'b0000001000000;
        @(negedge clk);
        stim = '0;
        check("R7", "dat_act before reset", dat_act_o, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1", 6'b000000);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule